// File: doc/BRIEF.md
# Auxiliary Port Multiplexing Handshake Detector

This block sits beside the host interface of a keyboard/auxiliary-port controller. It follows the bytes that the host loads into the auxiliary output buffer. To load one, the host writes the load-auxiliary-buffer command (0xD3) and then a data byte. The block echoes each loaded byte back as the byte that becomes readable in the output buffer. It also runs a sequence matcher over these loads.

Three loads carrying 0xF0, 0x56 and then a key byte form a handshake. With key 0xA4 the controller enters multiplexed mode. With key 0xA5 it returns to legacy mode. In both cases the third echoed byte is replaced by a version number, so host software can see that the feature exists. The deactivating form is answered in either mode. Software can therefore probe for the feature without switching it on.

In multiplexed mode, routing prefix commands 0x90 to 0x93 choose which of four auxiliary devices the next auxiliary transfer goes to. The block presents that choice as a device index. Switching the serial lines between devices is handled elsewhere.

Top module: `aux_mux_detect`

## Requirements
- R1: While reset is high and after it is released, `mux_mode` is 0, `dev_sel` is 0 and `echo_valid` is 0.
- R2: A data strobe that comes while a preceding command strobe carried 0xD3 (and no command came in between) raises `echo_valid` for one cycle, one cycle after the data strobe. `echo_byte` then equals the data byte, unless R3 or R4 substitutes it. A data strobe with no such preceding 0xD3 produces no echo.
- R3: Three consecutive loads of 0xF0, 0x56, 0xA4 make the third echo equal `VERSION` instead of 0xA4. `mux_mode` reads 1 in the same cycle as that echo.
- R4: Three consecutive loads of 0xF0, 0x56, 0xA5 make the third echo equal `VERSION`. `mux_mode` reads 0 in the same cycle as that echo, whether it was 0 or 1 before.
- R5: A loaded byte that does not match the expected next byte of the sequence returns the matcher to idle, and the byte is echoed unchanged. So 0xF0, 0x57, 0xA4 and 0xF0, 0xF0, 0x56, 0xA4 both leave the mode unchanged.
- R6: Any command other than 0xD3, and any data strobe that is not a load, that arrives between loads returns the matcher to idle.
- R7: In multiplexed mode, command 0x90+k (k = 0..3) sets `dev_sel` to k from the cycle after the strobe. Other commands leave `dev_sel` unchanged.
- R8: Outside multiplexed mode, commands 0x90 to 0x93 have no effect and `dev_sel` stays 0. Leaving multiplexed mode returns `dev_sel` to 0 in the same cycle as the mode change.
- R9: When a command strobe and a data strobe come in the same cycle, the command is taken and the data byte is dropped without an echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command write strobe |
| cmd_byte | input | 8 | Command byte |
| dat_valid | input | 1 | Host data write strobe |
| dat_byte | input | 8 | Data byte |
| mux_mode | output | 1 | 1 in multiplexed mode |
| dev_sel | output | DEV_W | Selected auxiliary device index |
| echo_valid | output | 1 | One-cycle pulse, a byte enters the auxiliary output buffer |
| echo_byte | output | 8 | Byte placed in the output buffer |

## Verification
A matcher stuck in a half-matched state shows up at the ports as an early or missed `VERSION` echo and a wrong `mux_mode`. This appears one cycle after the load that ends the sequence. A lost pending-load flag shows up on the very next data strobe, as a missing or extra echo, which the scoreboard catches because every expected echo is queued in order. A wrong route register shows up on `dev_sel` one cycle after a prefix command, or as a nonzero index in legacy mode.

// File: rtl/aux_mux_pkg.sv
package aux_mux_pkg;
  localparam logic [7:0] CMD_LOAD_AUX = 8'hD3;
  localparam logic [7:0] SEQ_B0       = 8'hF0;
  localparam logic [7:0] SEQ_B1       = 8'h56;
  localparam logic [7:0] KEY_ENTER    = 8'hA4;
  localparam logic [7:0] KEY_LEAVE    = 8'hA5;
  localparam logic [7:0] ROUTE_BASE   = 8'h90;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ONE  = 2'd1,
    SQ_TWO  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/aux_mux_decode.sv
module aux_mux_decode
  import aux_mux_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = $clog2(NUM_DEV)
) (
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  output logic             load_cmd,
  output logic             route_cmd,
  output logic [DEV_W-1:0] route_idx
);
  logic [7:0] offset;

  always_comb begin
    offset    = cmd_byte - ROUTE_BASE;
    load_cmd  = cmd_valid && (cmd_byte == CMD_LOAD_AUX);
    route_cmd = cmd_valid && (cmd_byte >= ROUTE_BASE) &&
                (int'(offset) < NUM_DEV);
    route_idx = offset[DEV_W-1:0];
  end
endmodule

// File: rtl/aux_mux_seq.sv
module aux_mux_seq
  import aux_mux_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'hC1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       load_cmd,
  input  logic       dat_valid,
  input  logic [7:0] dat_byte,
  output logic       hit_enter,
  output logic       hit_leave,
  output logic       echo_valid,
  output logic [7:0] echo_byte
);
  seq_state_t state, state_nxt;
  logic       armed;
  logic       take;

  always_comb begin
    take      = dat_valid && !cmd_valid && armed;
    state_nxt = SQ_IDLE;
    hit_enter = 1'b0;
    hit_leave = 1'b0;
    case (state)
      SQ_IDLE: if (dat_byte == SEQ_B0) state_nxt = SQ_ONE;
      SQ_ONE:  if (dat_byte == SEQ_B1) state_nxt = SQ_TWO;
      SQ_TWO: begin
        hit_enter = take && (dat_byte == KEY_ENTER);
        hit_leave = take && (dat_byte == KEY_LEAVE);
      end
      default: state_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      armed      <= 1'b0;
      echo_valid <= 1'b0;
      echo_byte  <= 8'h00;
    end else begin
      echo_valid <= 1'b0;
      if (cmd_valid) begin
        armed <= load_cmd;
        if (!load_cmd) state <= SQ_IDLE;
      end else if (dat_valid) begin
        armed <= 1'b0;
        if (armed) begin
          echo_valid <= 1'b1;
          echo_byte  <= (hit_enter || hit_leave) ? VERSION : dat_byte;
          state      <= state_nxt;
        end else begin
          state <= SQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/aux_mux_route.sv
module aux_mux_route #(
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mux_mode,
  input  logic             leaving,
  input  logic             route_cmd,
  input  logic [DEV_W-1:0] route_idx,
  output logic [DEV_W-1:0] dev_sel
);
  always_ff @(posedge clk) begin
    if (rst || !mux_mode || leaving) dev_sel <= '0;
    else if (route_cmd)              dev_sel <= route_idx;
  end
endmodule

// File: rtl/aux_mux_detect.sv
module aux_mux_detect
  import aux_mux_pkg::*;
#(
  parameter int         NUM_DEV = 4,
  parameter int         DEV_W   = $clog2(NUM_DEV),
  parameter logic [7:0] VERSION = 8'hC1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             dat_valid,
  input  logic [7:0]       dat_byte,
  output logic             mux_mode,
  output logic [DEV_W-1:0] dev_sel,
  output logic             echo_valid,
  output logic [7:0]       echo_byte
);
  logic             load_cmd, route_cmd;
  logic [DEV_W-1:0] route_idx;
  logic             hit_enter, hit_leave;

  aux_mux_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .load_cmd  (load_cmd),
    .route_cmd (route_cmd),
    .route_idx (route_idx)
  );

  aux_mux_seq #(.VERSION(VERSION)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .load_cmd   (load_cmd),
    .dat_valid  (dat_valid),
    .dat_byte   (dat_byte),
    .hit_enter  (hit_enter),
    .hit_leave  (hit_leave),
    .echo_valid (echo_valid),
    .echo_byte  (echo_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)            mux_mode <= 1'b0;
    else if (hit_enter) mux_mode <= 1'b1;
    else if (hit_leave) mux_mode <= 1'b0;
  end

  aux_mux_route #(.DEV_W(DEV_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .mux_mode  (mux_mode),
    .leaving   (hit_leave),
    .route_cmd (route_cmd),
    .route_idx (route_idx),
    .dev_sel   (dev_sel)
  );
endmodule

// File: rtl/aux_mux_detect_chk.sv
module aux_mux_detect_chk #(
  parameter int         DEV_W   = 2,
  parameter logic [7:0] VERSION = 8'hC1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             dat_valid,
  input logic [7:0]       dat_byte,
  input logic             mux_mode,
  input logic [DEV_W-1:0] dev_sel,
  input logic             echo_valid,
  input logic [7:0]       echo_byte
);
  a_r2_echo_needs_data: assert property (@(posedge clk) disable iff (rst)
    echo_valid |-> $past(dat_valid && !cmd_valid));

  a_r2_echo_copies_data: assert property (@(posedge clk) disable iff (rst)
    (echo_valid && echo_byte != VERSION) |-> echo_byte == $past(dat_byte));

  a_r3_enter_with_version: assert property (@(posedge clk) disable iff (rst)
    $rose(mux_mode) |-> (echo_valid && echo_byte == VERSION));

  a_r4_leave_with_version: assert property (@(posedge clk) disable iff (rst)
    $fell(mux_mode) |-> (echo_valid && echo_byte == VERSION));

  a_r8_legacy_index_zero: assert property (@(posedge clk) disable iff (rst)
    !mux_mode |-> dev_sel == '0);

  a_r7_index_moves_on_prefix: assert property (@(posedge clk) disable iff (rst)
    (mux_mode && !$stable(dev_sel)) |->
      ($past(cmd_valid) && $past(cmd_byte[7:4]) == 4'h9));
endmodule

bind aux_mux_detect aux_mux_detect_chk #(.DEV_W(DEV_W), .VERSION(VERSION)) u_chk (.*);

// File: tb/tb_aux_mux_detect.sv
module tb_aux_mux_detect;
  localparam logic [7:0] VER = 8'hC1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       dat_valid = 1'b0;
  logic [7:0] dat_byte = 8'h00;
  logic       mux_mode;
  logic [1:0] dev_sel;
  logic       echo_valid;
  logic [7:0] echo_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  aux_mux_detect #(.NUM_DEV(4), .VERSION(VER)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .mux_mode(mux_mode),
    .dev_sel(dev_sel), .echo_valid(echo_valid), .echo_byte(echo_byte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected echoes in order
  always @(negedge clk) begin
    if (!rst && echo_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected echo: actual %h expected none", echo_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (echo_byte !== e) begin
          fails++;
          $display("FAIL %s echo: actual %h expected %h", t, echo_byte, e);
        end
      end
    end
  end

  task automatic aux_load(input logic [7:0] b, input logic [7:0] e, input string t);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = 8'hD3;
    @(negedge clk); cmd_valid = 1'b0; dat_valid = 1'b1; dat_byte = b;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); dat_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic plain_data(input logic [7:0] b, input string t);
    @(negedge clk); dat_valid = 1'b1; dat_byte = b;
    @(negedge clk); dat_valid = 1'b0;
    chk(t, {7'd0, echo_valid}, 8'h00);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", {7'd0, mux_mode}, 8'h00);
    chk("R1 dev_sel in reset", {6'd0, dev_sel}, 8'h00);
    chk("R1 echo in reset", {7'd0, echo_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode after reset", {7'd0, mux_mode}, 8'h00);

    // R2 plain echoes and non-load data
    aux_load(8'h11, 8'h11, "R2");
    aux_load(8'hA4, 8'hA4, "R2");
    plain_data(8'h33, "R2 data without load");

    // R4 probe in legacy mode
    aux_load(8'hF0, 8'hF0, "R4");
    aux_load(8'h56, 8'h56, "R4");
    aux_load(8'hA5, VER,   "R4");
    chk("R4 legacy probe keeps mode", {7'd0, mux_mode}, 8'h00);

    // R8 prefix ignored in legacy
    send_cmd(8'h92);
    chk("R8 prefix ignored", {6'd0, dev_sel}, 8'h00);

    // R5 mismatches
    aux_load(8'hF0, 8'hF0, "R5");
    aux_load(8'h57, 8'h57, "R5");
    aux_load(8'hA4, 8'hA4, "R5");
    chk("R5 mismatch no mode", {7'd0, mux_mode}, 8'h00);
    aux_load(8'hF0, 8'hF0, "R5");
    aux_load(8'hF0, 8'hF0, "R5");
    aux_load(8'h56, 8'h56, "R5");
    aux_load(8'hA4, 8'hA4, "R5");
    chk("R5 repeated first byte no mode", {7'd0, mux_mode}, 8'h00);

    // R6 interleaved command and interleaved plain data
    aux_load(8'hF0, 8'hF0, "R6");
    send_cmd(8'h20);
    aux_load(8'h56, 8'h56, "R6");
    aux_load(8'hA4, 8'hA4, "R6");
    chk("R6 other command resets", {7'd0, mux_mode}, 8'h00);
    aux_load(8'hF0, 8'hF0, "R6");
    aux_load(8'h56, 8'h56, "R6");
    plain_data(8'h44, "R6 stray data");
    aux_load(8'hA4, 8'hA4, "R6");
    chk("R6 stray data resets", {7'd0, mux_mode}, 8'h00);

    // R3 activation
    aux_load(8'hF0, 8'hF0, "R3");
    aux_load(8'h56, 8'h56, "R3");
    aux_load(8'hA4, VER,   "R3");
    chk("R3 mode entered", {7'd0, mux_mode}, 8'h01);

    // R7 routing prefixes
    send_cmd(8'h93);
    chk("R7 prefix 3", {6'd0, dev_sel}, 8'h03);
    send_cmd(8'h90);
    chk("R7 prefix 0", {6'd0, dev_sel}, 8'h00);
    send_cmd(8'h91);
    chk("R7 prefix 1", {6'd0, dev_sel}, 8'h01);
    send_cmd(8'h94);
    chk("R7 out-of-range keeps index", {6'd0, dev_sel}, 8'h01);
    send_cmd(8'h20);
    chk("R7 other command keeps index", {6'd0, dev_sel}, 8'h01);

    // R9 simultaneous strobes: command wins, data dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'hD3; dat_valid = 1'b1; dat_byte = 8'hF0;
    @(negedge clk);
    cmd_valid = 1'b0; dat_valid = 1'b0;
    chk("R9 data dropped", {7'd0, echo_valid}, 8'h00);
    @(negedge clk); dat_valid = 1'b1; dat_byte = 8'h77;
    exp_q.push_back(8'h77); tag_q.push_back("R9 command kept");
    @(negedge clk); dat_valid = 1'b0;

    // R4 deactivation from multiplexed mode, R8 index cleared
    aux_load(8'hF0, 8'hF0, "R4");
    aux_load(8'h56, 8'h56, "R4");
    aux_load(8'hA5, VER,   "R4");
    chk("R4 mode left", {7'd0, mux_mode}, 8'h00);
    chk("R8 index cleared on leave", {6'd0, dev_sel}, 8'h00);

    repeat (3) @(negedge clk);
    chk("R2 all expected echoes seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule